// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for one agent attached to a 32-bit multiplexed address/data bus with four command/byte-enable lines. When the agent owns the bus, the block registers the parity of all thirty-six address/data and command/byte-enable lines on every clock. It presents that value on the parity output one clock later. The parity output enable is the agent's address/data output enable, delayed by one clock. Parity therefore stays driven for the clock after the agent's last data phase.

When the agent is receiving, the block takes a snapshot of the parity of the lines on every valid address or data phase. On the next clock it compares that snapshot with the parity bit arriving from the other agent. A mismatch always sets a sticky detected-error status bit, which software clears by writing a one. An error request is raised only when the command-register response enable is set. A data-phase error raises a one-clock data-parity error request. An address-phase error raises a one-clock system-error request instead. The phase type, bus command and byte enables never exclude any line from the calculation.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_o` equals the even parity (XOR) of `ad_i` and `cbe_i` as sampled on the previous rising edge. The ones in that `ad_i`, `cbe_i` and `par_o` together always total an even number.
- R2: `par_oe_o` equals `ad_oe_i` delayed by exactly one clock.
- R3: All 32 `ad_i` lines and all 4 `cbe_i` lines enter the parity on every clock, whatever the phase type, command code or byte-enable value.
- R4: A receive phase is a clock with `addr_phase_i` or `data_phase_i` high and `ad_oe_i` low. In the next clock, `par_i` is compared with the parity of that phase's `ad_i`/`cbe_i`. A mismatch is a parity error.
- R5: A parity error sets `dpe_sts_o` two clocks after the phase, whatever the value of `resp_en_i`.
- R6: A data-phase parity error (`data_phase_i` high, `addr_phase_i` low) raises `perr_req_o` for exactly one clock, two clocks after the phase. This happens only if `resp_en_i` was high in the clock that follows the phase.
- R7: An address-phase parity error (`addr_phase_i` high) raises `serr_req_o` for one clock, two clocks after the phase, under the same enable condition. It never raises `perr_req_o`.
- R8: While `resp_en_i` is low in the clock after a phase, an error in that phase leaves `perr_req_o` and `serr_req_o` low.
- R9: `dpe_sts_o` holds its value until `sts_clr_i` is high for a clock. It then reads 0 from the next clock on. A new error in the same clock takes precedence and keeps it at 1.
- R10: While `rst_n` is low at a rising edge, every output is 0 after that edge.
- R11: No error is flagged for a clock in which the agent drives (`ad_oe_i` high) or in which neither phase qualifier is high, whatever `par_i` carries in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_i | input | 4 | Command/byte-enable lines as seen on the bus |
| par_i | input | 1 | Parity line as seen on the bus |
| addr_phase_i | input | 1 | Valid address phase in this clock |
| data_phase_i | input | 1 | Valid data transfer in this clock |
| ad_oe_i | input | 1 | Agent is driving address/data in this clock |
| resp_en_i | input | 1 | Parity error response enable from the command register |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity output enable |
| perr_req_o | output | 1 | Data parity error request |
| serr_req_o | output | 1 | System error request for an address parity error |
| dpe_sts_o | output | 1 | Detected parity error status bit |

## Verification
The parity output and its enable are due one clock after the bus values they cover. The error requests and the status bit are due two clocks after a receive phase: one clock to take in the parity bit, one to register the verdict. A clear strobe takes effect one clock after it is applied. The bench keeps a history of the inputs it applied at each edge and derives every expected output from the entries one and two edges back. It drives inputs on the falling edge and compares all five outputs on the next falling edge, so each result is checked in the clock it becomes due and in no other.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             par_i,
  input  logic             addr_phase_i,
  input  logic             data_phase_i,
  input  logic             ad_oe_i,
  input  logic             resp_en_i,
  input  logic             sts_clr_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_req_o,
  output logic             serr_req_o,
  output logic             dpe_sts_o
);

  logic bus_par;
  logic rx_phase;
  logic mismatch;

  logic par_q, oe_q;
  logic chk_v_q, chk_addr_q, chk_par_q;
  logic perr_q, serr_q, dpe_q;

  assign bus_par  = ^{ad_i, cbe_i};
  assign rx_phase = (addr_phase_i | data_phase_i) & ~ad_oe_i;
  assign mismatch = chk_v_q & (par_i ^ chk_par_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q      <= 1'b0;
      oe_q       <= 1'b0;
      chk_v_q    <= 1'b0;
      chk_addr_q <= 1'b0;
      chk_par_q  <= 1'b0;
      perr_q     <= 1'b0;
      serr_q     <= 1'b0;
      dpe_q      <= 1'b0;
    end else begin
      par_q      <= bus_par;
      oe_q       <= ad_oe_i;
      chk_v_q    <= rx_phase;
      chk_addr_q <= addr_phase_i;
      chk_par_q  <= bus_par;
      perr_q     <= mismatch & ~chk_addr_q & resp_en_i;
      serr_q     <= mismatch &  chk_addr_q & resp_en_i;
      if (mismatch)
        dpe_q <= 1'b1;
      else if (sts_clr_i)
        dpe_q <= 1'b0;
    end
  end

  assign par_o      = par_q;
  assign par_oe_o   = oe_q;
  assign perr_req_o = perr_q;
  assign serr_req_o = serr_q;
  assign dpe_sts_o  = dpe_q;

endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AD_W-1:0]  ad_i,
  input logic [CBE_W-1:0] cbe_i,
  input logic             par_i,
  input logic             addr_phase_i,
  input logic             data_phase_i,
  input logic             ad_oe_i,
  input logic             resp_en_i,
  input logic             sts_clr_i,
  input logic             par_o,
  input logic             par_oe_o,
  input logic             perr_req_o,
  input logic             serr_req_o,
  input logic             dpe_sts_o
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_even_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0));

  p_oe_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (par_oe_o == $past(ad_oe_i)));

  p_no_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(resp_en_i)) |-> (!perr_req_o && !serr_req_o));

  p_status_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_req_o || serr_req_o) |-> dpe_sts_o);

  p_one_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(perr_req_o && serr_req_o));

  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dpe_sts_o && !sts_clr_i) |=> dpe_sts_o);

  p_quiet_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ad_oe_i) && !dpe_sts_o) |=> !$rose(dpe_sts_o));

endmodule

bind pci_parity_unit pci_parity_unit_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
  .addr_phase_i(addr_phase_i), .data_phase_i(data_phase_i), .ad_oe_i(ad_oe_i),
  .resp_en_i(resp_en_i), .sts_clr_i(sts_clr_i), .par_o(par_o),
  .par_oe_o(par_oe_o), .perr_req_o(perr_req_o), .serr_req_o(serr_req_o),
  .dpe_sts_o(dpe_sts_o)
);

// File: tb/pci_parity_unit_tb.sv
`timescale 1ns/1ps
module pci_parity_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        par_i = 1'b0;
  logic        addr_phase_i = 1'b0, data_phase_i = 1'b0, ad_oe_i = 1'b0;
  logic        resp_en_i = 1'b0, sts_clr_i = 1'b0;
  logic        par_o, par_oe_o, perr_req_o, serr_req_o, dpe_sts_o;

  always #2 clk = ~clk;

  pci_parity_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
    .addr_phase_i(addr_phase_i), .data_phase_i(data_phase_i), .ad_oe_i(ad_oe_i),
    .resp_en_i(resp_en_i), .sts_clr_i(sts_clr_i), .par_o(par_o),
    .par_oe_o(par_oe_o), .perr_req_o(perr_req_o), .serr_req_o(serr_req_o),
    .dpe_sts_o(dpe_sts_o)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // history of applied inputs, newest first
  typedef struct packed {
    logic [31:0] ad; logic [3:0] cbe; logic par;
    logic ap; logic dp; logic oe; logic resp; logic clr;
  } snap_t;
  snap_t hist[$];

  logic e_par, e_oe, e_perr, e_serr, e_dpe;

  function automatic int ones(input logic [31:0] a, input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    for (int i = 0; i < 4; i++)  n += int'(c[i]);
    return n;
  endfunction

  // reference model, evaluated on each rising edge from the applied inputs
  always @(posedge clk) begin
    snap_t s;
    bit err;
    s = '{ad_i, cbe_i, par_i, addr_phase_i, data_phase_i, ad_oe_i, resp_en_i, sts_clr_i};
    if (!rst_n) begin
      hist.delete();
      e_par = 0; e_oe = 0; e_perr = 0; e_serr = 0; e_dpe = 0;  // R10
    end else begin
      hist.push_front(s);
      if (hist.size() > 2) void'(hist.pop_back());
      e_par = (ones(s.ad, s.cbe) % 2) == 1;                    // R1, R3
      e_oe  = s.oe;                                            // R2
      err = 0;
      if (hist.size() == 2)                                    // R4, R11
        if ((hist[1].ap || hist[1].dp) && !hist[1].oe)
          err = ((ones(hist[1].ad, hist[1].cbe) + int'(s.par)) % 2) != 0;
      e_perr = err && !hist[1].ap && s.resp;                   // R6, R8
      e_serr = err &&  hist[1].ap && s.resp;                   // R7, R8
      if (err) e_dpe = 1;                                      // R5
      else if (s.clr) e_dpe = 0;                               // R9
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      cmp("R1 par_o", par_o, e_par);
      cmp("R2 par_oe_o", par_oe_o, e_oe);
      cmp("R6 perr_req_o", perr_req_o, e_perr);
      cmp("R7 serr_req_o", serr_req_o, e_serr);
      cmp("R5 R9 dpe_sts_o", dpe_sts_o, e_dpe);
    end
  end

  logic [31:0] prev_ad = '0;
  logic [3:0]  prev_cbe = '0;

  // one clock of stimulus: par_i covers the previous clock's bus, optionally corrupted
  task automatic step(input logic [31:0] ad, input logic [3:0] cbe,
                      input logic ap, input logic dp, input logic oe,
                      input logic bad, input logic resp, input logic clr);
    par_i = (ones(prev_ad, prev_cbe) % 2 == 1) ^ bad;
    ad_i = ad; cbe_i = cbe;
    addr_phase_i = ap; data_phase_i = dp; ad_oe_i = oe;
    resp_en_i = resp; sts_clr_i = clr;
    prev_ad = ad; prev_cbe = cbe;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic resp);
    step(32'h0, 4'h0, 0, 0, 0, 0, resp, 0);
  endtask

  initial begin
    @(negedge clk);
    // R10: reset state with busy inputs
    for (int i = 0; i < 3; i++) step($urandom, 4'($urandom), 1, 1, 1, 1, 1, 0);
    rst_n = 1'b1;
    // R1 R2 R3: agent drives; address phase with config-type command, then data with partial byte enables
    step(32'h8000_0A14, 4'hA, 1, 0, 1, 0, 1, 0);
    step(32'hDEAD_BEEF, 4'h3, 0, 1, 1, 0, 1, 0);
    step(32'hFFFF_FFFF, 4'hF, 0, 1, 1, 0, 1, 0);
    step(32'h0000_0001, 4'h0, 0, 1, 1, 0, 1, 0);
    step(32'h0, 4'h0, 0, 0, 0, 0, 1, 0);  // R2: enable still high for one clock
    idle(1);
    // R4: clean receive data phase
    step(32'h1234_5678, 4'h0, 0, 1, 0, 0, 1, 0);
    idle(1); idle(1);
    // R6: corrupted data phase with response enabled
    step(32'hCAFE_F00D, 4'h5, 0, 1, 0, 0, 1, 0);
    step(32'h0, 4'h0, 0, 0, 0, 1, 1, 0);
    idle(1); idle(1);
    // R9: write-one-to-clear
    step(32'h0, 4'h0, 0, 0, 0, 0, 1, 1);
    idle(1);
    // R7: address phase error raises the system error request
    step(32'h0000_0100, 4'hB, 1, 0, 0, 0, 1, 0);
    step(32'h0, 4'h0, 0, 0, 0, 1, 1, 0);
    idle(1); idle(1);
    step(32'h0, 4'h0, 0, 0, 0, 0, 1, 1);
    // R8: response disabled, status still set (R5)
    step(32'h7777_0000, 4'h2, 0, 1, 0, 0, 0, 0);
    step(32'h0, 4'h0, 0, 0, 0, 1, 0, 0);
    idle(0); idle(0);
    // R9: clear coinciding with a fresh error keeps the bit set
    step(32'h0000_00FF, 4'h1, 0, 1, 0, 0, 1, 0);
    step(32'h0, 4'h0, 0, 0, 0, 1, 1, 1);
    idle(1); idle(1);
    step(32'h0, 4'h0, 0, 0, 0, 0, 1, 1);
    // R11: bad parity after a driven phase and after a non-phase clock
    step(32'h5555_AAAA, 4'h6, 0, 1, 1, 0, 1, 0);
    step(32'h0F0F_0F0F, 4'h9, 0, 0, 0, 1, 1, 0);
    step(32'h0, 4'h0, 0, 0, 0, 1, 1, 0);
    idle(1); idle(1);
    // R6: back-to-back data phase errors
    step(32'h1, 4'h0, 0, 1, 0, 0, 1, 0);
    step(32'h2, 4'h0, 0, 1, 0, 1, 1, 0);
    step(32'h0, 4'h0, 0, 0, 0, 1, 1, 0);
    idle(1); idle(1);
    // mixed random traffic, R1 through R11
    for (int i = 0; i < 3000; i++)
      step($urandom, 4'($urandom), ($urandom % 4) == 0, ($urandom % 2) == 0,
           ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 4) != 0,
           ($urandom % 7) == 0);
    // R10: reset mid-traffic
    rst_n = 1'b0;
    step(32'hFFFF_FFFF, 4'hF, 1, 1, 1, 1, 1, 0);
    step(32'hFFFF_FFFF, 4'hF, 1, 1, 1, 1, 1, 0);
    rst_n = 1'b1;
    idle(1); idle(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule